// File: doc/BRIEF.md
# Self-Scrubbing Triple-Redundant Register

This block is a storage register that tolerates single-event upsets. It keeps three separate copies of every stored bit. The output is the bitwise majority of the three copies, so one corrupted copy never reaches the rest of the chip. When no new value is being loaded, the voted value is written back into all three copies on every clock edge. A single flipped copy is therefore repaired at the next edge, before a second upset can land on the same bit in another copy.

All three copies are clocked by the same edge. Loading uses a synchronous enable, and no clock is gated. A registered flag reports any cycle in which the copies disagreed, so that upset activity can be counted elsewhere. A debug port can flip a chosen bit in any chosen set of copies as that edge writes them. This lets a bench reproduce upsets in a controlled way. Two copies flipped on the same bit before a refresh cannot be corrected. The block then reports the event through the flag and keeps the wrong value.

Top module: `tmr_scrub_reg`

## Requirements
- R1: A synchronous reset (`rst` high at an edge) sets all three copies to `RST_VAL` (default 8'hA5) and clears `mismatch`. Reset wins over load and over injection.
- R2: With `ld_en` high at an edge, `q_out` equals the `d_in` sampled at that edge from the next cycle on.
- R3: With `ld_en` low and no injection, `q_out` keeps its value across the edge.
- R4: Flipping a single copy never changes `q_out`. After the edge, `q_out` shows what it would have shown with no injection (the loaded value, or the held value).
- R5: With no injection at an edge, all three copies agree after that edge. A single upset is scrubbed by the first following edge, whether that edge refreshes or loads.
- R6: `mismatch` is registered. After each edge it shows whether the three copies disagreed in the cycle before that edge, so one upset raises it for exactly one cycle.
- R7: Flipping the same bit in two copies at one edge changes that bit of `q_out` to the flipped value. It raises `mismatch` once, and the refresh then keeps the wrong value in all copies.
- R8: Injection encoding: when `inj_en` is high, bit k of `inj_mask` selects copy k (k = 0, 1, 2). `inj_bit` is the bit index that is inverted in the value written to the selected copies at that edge. Selecting all three copies changes `q_out` without raising `mismatch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all copies |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Load enable: write `d_in` into all copies |
| d_in | input | WIDTH | Data to load |
| inj_en | input | 1 | Debug upset injection enable |
| inj_mask | input | 3 | Copies to corrupt, bit k = copy k |
| inj_bit | input | IDX_W | Index of the bit to invert |
| q_out | output | WIDTH | Majority-voted stored value |
| mismatch | output | 1 | Registered copy-disagreement flag |

## Verification
The hardest state to reach from the ports is a double upset on one bit. A refresh between two separate single-copy injections repairs the first before the second lands, so the two can never be combined that way. The stimulus reaches this state by setting two bits of `inj_mask` in one cycle. The bench then checks that the wrong value persists and that the flag pulses once. Single upsets are also placed on edges that load, to show that loading scrubs as well as refreshing does.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int NCOPY = 3;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction
endpackage

// File: rtl/tmr_copy_reg.sv
module tmr_copy_reg #(
   parameter int WIDTH = 8,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] wr_val,
   input  logic [WIDTH-1:0] flip,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst) q <= RST_VAL;
      else     q <= wr_val ^ flip;
   end
endmodule

// File: rtl/tmr_voter.sv
module tmr_voter
   import tmr_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [WIDTH-1:0] c,
   output logic [WIDTH-1:0] vote,
   output logic             disagree
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign vote[i] = maj3(a[i], b[i], c[i]);
   end
   assign disagree = |((a ^ b) | (b ^ c));
endmodule

// File: rtl/tmr_inject.sv
module tmr_inject
   import tmr_pkg::*;
#(
   parameter int WIDTH = 8,
   parameter int IDX_W = 3,
   parameter bit ENABLE = 1'b1
) (
   input  logic                         inj_en,
   input  logic [NCOPY-1:0]             inj_mask,
   input  logic [IDX_W-1:0]             inj_bit,
   output logic [NCOPY-1:0][WIDTH-1:0]  flip
);
   localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

   if (ENABLE) begin : g_inj
      logic [WIDTH-1:0] pos;
      assign pos = ONE << inj_bit;
      for (genvar k = 0; k < NCOPY; k++) begin : g_copy
         assign flip[k] = (inj_en && inj_mask[k]) ? pos : '0;
      end
   end else begin : g_noinj
      logic unused_ok;
      assign unused_ok = &{1'b0, inj_en, inj_mask, inj_bit};
      assign flip = '0;
   end
endmodule

// File: rtl/tmr_scrub_reg.sv
module tmr_scrub_reg
   import tmr_pkg::*;
#(
   parameter int WIDTH = 8,
   parameter logic [WIDTH-1:0] RST_VAL = 8'hA5,
   parameter bit INJ_ENABLE = 1'b1,
   localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld_en,
   input  logic [WIDTH-1:0] d_in,
   input  logic             inj_en,
   input  logic [2:0]       inj_mask,
   input  logic [IDX_W-1:0] inj_bit,
   output logic [WIDTH-1:0] q_out,
   output logic             mismatch
);
   if (WIDTH < 1) begin : g_bad_width
      $error("tmr_scrub_reg: WIDTH must be at least 1");
   end
   if (NCOPY != 3) begin : g_bad_copies
      $error("tmr_scrub_reg: majority voting needs exactly three copies");
   end

   logic [WIDTH-1:0]             copy_q [NCOPY];
   logic [NCOPY-1:0][WIDTH-1:0]  flip;
   logic [WIDTH-1:0]             voted;
   logic [WIDTH-1:0]             wr_val;
   logic                         disagree;

   tmr_voter #(.WIDTH(WIDTH)) u_vote (
      .a(copy_q[0]), .b(copy_q[1]), .c(copy_q[2]),
      .vote(voted), .disagree(disagree)
   );

   tmr_inject #(.WIDTH(WIDTH), .IDX_W(IDX_W), .ENABLE(INJ_ENABLE)) u_inj (
      .inj_en(inj_en), .inj_mask(inj_mask), .inj_bit(inj_bit), .flip(flip)
   );

   assign wr_val = ld_en ? d_in : voted;

   for (genvar k = 0; k < NCOPY; k++) begin : g_copy
      tmr_copy_reg #(.WIDTH(WIDTH), .RST_VAL(RST_VAL)) u_copy (
         .clk(clk), .rst(rst), .wr_val(wr_val), .flip(flip[k]), .q(copy_q[k])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) mismatch <= 1'b0;
      else     mismatch <= disagree;
   end

   assign q_out = voted;
endmodule

// File: rtl/tmr_scrub_reg_chk.sv
module tmr_scrub_reg_chk #(
   parameter int WIDTH = 8,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input logic             clk,
   input logic             rst,
   input logic             ld_en,
   input logic [WIDTH-1:0] d_in,
   input logic             inj_en,
   input logic [2:0]       inj_mask,
   input logic [WIDTH-1:0] q_out,
   input logic             mismatch,
   input logic [WIDTH-1:0] c0,
   input logic [WIDTH-1:0] c1,
   input logic [WIDTH-1:0] c2
);
   AST_RESET_STATE: assert property (@(posedge clk) rst |=> (q_out == RST_VAL && !mismatch)); // R1
   AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst) (ld_en && !inj_en) |=> q_out == $past(d_in)); // R2
   AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (rst) (!ld_en && !inj_en) |=> $stable(q_out)); // R3
   AST_SINGLE_MASKED: assert property (@(posedge clk) disable iff (rst) (inj_en && $countones(inj_mask) == 1) |=> q_out == $past(ld_en ? d_in : q_out)); // R4
   AST_SCRUBBED: assert property (@(posedge clk) disable iff (rst) !inj_en |=> (c0 == c1 && c1 == c2)); // R5
   AST_FLAG_DELAY: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> mismatch == $past(c0 != c1 || c1 != c2)); // R6
endmodule

bind tmr_scrub_reg tmr_scrub_reg_chk #(.WIDTH(WIDTH), .RST_VAL(RST_VAL)) u_chk (
   .clk(clk), .rst(rst), .ld_en(ld_en), .d_in(d_in), .inj_en(inj_en),
   .inj_mask(inj_mask), .q_out(q_out), .mismatch(mismatch),
   .c0(copy_q[0]), .c1(copy_q[1]), .c2(copy_q[2])
);

// File: tb/test_tmr_scrub_reg.sv
module test_tmr_scrub_reg;
   localparam int W = 8;
   localparam logic [W-1:0] RV = 8'hA5;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         ld_en = 1'b0;
   logic [W-1:0] d_in = '0;
   logic         inj_en = 1'b0;
   logic [2:0]   inj_mask = '0;
   logic [2:0]   inj_bit = '0;
   logic [W-1:0] q_out;
   logic         mismatch;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tmr_scrub_reg #(.WIDTH(W), .RST_VAL(RV)) i_tmr_scrub_reg (
      .clk(clk), .rst(rst), .ld_en(ld_en), .d_in(d_in), .inj_en(inj_en),
      .inj_mask(inj_mask), .inj_bit(inj_bit), .q_out(q_out), .mismatch(mismatch)
   );

   // entry: ld, d, inj_en, mask, bit, expected q, expected mismatch
   localparam int NV = 14;
   localparam logic [24:0] VEC [NV] = '{
      {1'b1, 8'h3C, 1'b0, 3'b000, 3'd0, 8'h3C, 1'b0},  // R2 load
      {1'b0, 8'h00, 1'b0, 3'b000, 3'd0, 8'h3C, 1'b0},  // R3 hold
      {1'b0, 8'h00, 1'b1, 3'b001, 3'd2, 8'h3C, 1'b0},  // R4 copy0 bit2
      {1'b0, 8'h00, 1'b0, 3'b000, 3'd0, 8'h3C, 1'b1},  // R6 flag
      {1'b0, 8'h00, 1'b0, 3'b000, 3'd0, 8'h3C, 1'b0},  // R5 scrubbed
      {1'b1, 8'hC3, 1'b1, 3'b010, 3'd7, 8'hC3, 1'b0},  // R4 upset on load
      {1'b0, 8'h00, 1'b0, 3'b000, 3'd0, 8'hC3, 1'b1},  // R6
      {1'b0, 8'h00, 1'b1, 3'b011, 3'd0, 8'hC2, 1'b0},  // R7 double
      {1'b0, 8'h00, 1'b0, 3'b000, 3'd0, 8'hC2, 1'b1},  // R7 flag once
      {1'b0, 8'h00, 1'b0, 3'b000, 3'd0, 8'hC2, 1'b0},  // R7 persists
      {1'b1, 8'hFF, 1'b1, 3'b100, 3'd3, 8'hFF, 1'b0},  // R4 copy2 bit3
      {1'b1, 8'h00, 1'b0, 3'b000, 3'd0, 8'h00, 1'b1},  // R5 load scrubs
      {1'b0, 8'h00, 1'b1, 3'b111, 3'd5, 8'h20, 1'b0},  // R8 all copies
      {1'b0, 8'h00, 1'b0, 3'b000, 3'd0, 8'h20, 1'b0}   // R8 no flag
   };

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic l, input logic [W-1:0] d, input logic ie,
                       input logic [2:0] m, input logic [2:0] b);
      ld_en = l; d_in = d; inj_en = ie; inj_mask = m; inj_bit = b;
      @(negedge clk);
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      chk("R1 reset q", q_out, RV);
      chk("R1 reset flag", {7'd0, mismatch}, 8'd0);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][24], VEC[i][23:16], VEC[i][15], VEC[i][14:12], VEC[i][11:9]);
         chk($sformatf("R2-8 vec%0d q", i), q_out, VEC[i][8:1]);
         chk($sformatf("R6 vec%0d flag", i), {7'd0, mismatch}, {7'd0, VEC[i][0]});
      end

      // R1: reset wins over load and injection, and clears a pending flag
      step(1'b0, 8'h00, 1'b1, 3'b001, 3'd1);
      rst = 1'b1;
      step(1'b1, 8'h11, 1'b1, 3'b010, 3'd4);
      chk("R1 reset over load", q_out, RV);
      chk("R1 reset clears flag", {7'd0, mismatch}, 8'd0);
      rst = 1'b0;
      step(1'b0, 8'h00, 1'b0, 3'b000, 3'd0);
      chk("R1 after reset q", q_out, RV);
      chk("R1 copies agree after reset", {7'd0, mismatch}, 8'd0);

      // R4/R5: upset on every copy in turn, same bit, each scrubbed
      for (int k = 0; k < 3; k++) begin
         step(1'b0, 8'h00, 1'b1, 3'(1 << k), 3'd6);
         chk("R4 rotating upset", q_out, RV);
         step(1'b0, 8'h00, 1'b0, 3'b000, 3'd0);
         chk("R6 rotating flag", {7'd0, mismatch}, 8'd1);
      end
      step(1'b0, 8'h00, 1'b0, 3'b000, 3'd0);
      chk("R5 rotating scrubbed", {7'd0, mismatch}, 8'd0);
      chk("R3 rotating held", q_out, RV);

      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule